// File: doc/BRIEF.md
# Flash and EEPROM access protection controller

This block sits in front of the program flash and the data EEPROM. It judges every access request against the protection state in force and answers grant or deny. Each request names a memory space, an address, a read or write flag and an access mode. The mode is one of in-application, in-circuit programming or debug. The decision is registered, so it appears one cycle after the request.

The protection state has three parts. The first is a boot region at the bottom of program memory, sized in 64-byte pages. The second is a pair of key-sequence unlock machines, one for each memory space. The third is a read-out protection flag. The boot-region size and the initial flag come from a one-time settings load after reset, and every access is refused until that load has happened.

Turning read-out protection off while it is on does not take effect at once. The block first issues a one-cycle global erase request and then holds a busy flag until the memory side reports done. Denied writes raise a sticky error flag that software clears by writing one.

Top module: `flash_guard`

## Requirements
- R1: A request with `req_valid` high produces exactly one of `grant` or `deny` in the next cycle. Neither output is high in a cycle that follows a cycle without a request.
- R2: Every request is denied until `cfg_load` has been sampled once after reset. A request sampled in the same cycle as that load is also denied. Later `cfg_load` pulses are ignored.
- R3: A boot-region size of N pages protects program addresses below N×64. N = 0 protects nothing, and any N ≥ 128 protects all 8192 bytes. In-application writes into the boot region are denied even when program memory is unlocked.
- R4: Program space is `req_space`=0. In-application writes to it above the boot region are granted only after the key bytes 0x3C and then 0xA5 are written with `key_space`=0.
- R5: Data space is `req_space`=1. Its unlock sequence is 0xA5 and then 0x3C. Data addresses of 640 and above are always denied.
- R6: A wrong key byte jams that space until reset, and a later correct sequence does not open it. `lock_cmd` returns a space that is not jammed to locked, and it wins over a key byte in the same cycle.
- R7: In-application reads of in-range addresses are granted whatever the lock state.
- R8: Mode encoding is 0 for in-application, 1 for in-circuit programming, 2 for debug and 3 reserved. Mode 3 is always denied. Modes 1 and 2 are granted for reads and writes while read-out protection is off, and denied while it is on.
- R9: A request to turn read-out protection on while it is off takes effect in the next cycle with no erase. A request to turn it off while it is on raises `erase_req` for one cycle. `erase_busy` rises with that pulse and falls on the edge that samples `erase_done`, and the new protection state takes effect on that same edge.
- R10: While `erase_busy` is high, every request is denied and protection change requests are ignored. An `erase_done` while idle has no effect.
- R11: A denied write sets `err_flag` in the same cycle as its `deny`. `err_clr` clears the flag, but a new denied write in the same cycle wins. Denied reads leave the flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the settings below, honoured once after reset |
| cfg_pages | input | 8 | Boot-region size in 64-byte pages |
| cfg_rop | input | 1 | Initial read-out protection state |
| req_valid | input | 1 | Access request present |
| req_space | input | 1 | 0 program memory, 1 data EEPROM |
| req_addr | input | 13 | Byte address inside the space |
| req_write | input | 1 | 1 write, 0 read |
| req_mode | input | 2 | Access mode (see R8) |
| key_valid | input | 1 | Key byte strobe |
| key_space | input | 1 | Space the key byte is meant for |
| key_data | input | 8 | Key byte |
| lock_cmd | input | 1 | Relock both spaces |
| rop_set_valid | input | 1 | Read-out protection change request |
| rop_set_value | input | 1 | Requested protection state |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| erase_done | input | 1 | Memory side reports erase complete |
| grant | output | 1 | Request granted (one cycle after request) |
| deny | output | 1 | Request denied (one cycle after request) |
| err_flag | output | 1 | Sticky denied-write flag |
| erase_req | output | 1 | One-cycle global erase request |
| erase_busy | output | 1 | Erase in progress |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the end of an erase and an access request. The bench drives `erase_done` together with a request and expects a deny, because the request is judged against the busy state that held before the edge. It then expects a grant for the following in-circuit read under the new protection state. The second pair is a fresh denied write and an `err_clr`. The bench drives both in one cycle and expects the flag to stay set. A behavioural reference model in the bench is compared with every output on every clock.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    MODE_IAP = 2'd0,
    MODE_ICP = 2'd1,
    MODE_DBG = 2'd2,
    MODE_RSV = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    KS_LOCKED,
    KS_HALF,
    KS_OPEN,
    KS_JAMMED
  } key_st_e;
endpackage

// File: rtl/fg_keyseq.sv
module fg_keyseq
  import fg_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h3C,
  parameter logic [7:0] KEY_B = 8'hA5,
  parameter logic       SPACE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_valid,
  input  logic       key_space,
  input  logic [7:0] key_data,
  input  logic       lock_cmd,
  output logic       unlocked
);
  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_LOCKED;
    end else if (lock_cmd && st_q != KS_JAMMED) begin
      st_q <= KS_LOCKED;
    end else if (key_valid && key_space == SPACE) begin
      case (st_q)
        KS_LOCKED: st_q <= (key_data == KEY_A) ? KS_HALF : KS_JAMMED;
        KS_HALF:   st_q <= (key_data == KEY_B) ? KS_OPEN : KS_JAMMED;
        default:   st_q <= st_q;
      endcase
    end
  end

  assign unlocked = (st_q == KS_OPEN);
endmodule

// File: rtl/fg_rop_ctl.sv
module fg_rop_ctl (
  input  logic clk,
  input  logic rst,
  input  logic loaded,
  input  logic cfg_load,
  input  logic cfg_rop,
  input  logic rop_set_valid,
  input  logic rop_set_value,
  input  logic erase_done,
  output logic rop_q,
  output logic erase_req,
  output logic erase_busy
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rop_q      <= 1'b0;
      erase_req  <= 1'b0;
      erase_busy <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      erase_req <= 1'b0;
      if (!loaded && cfg_load) begin
        rop_q <= cfg_rop;
      end else if (erase_busy) begin
        if (erase_done) begin
          erase_busy <= 1'b0;
          rop_q      <= pend_q;
        end
      end else if (loaded && rop_set_valid && rop_set_value != rop_q) begin
        if (rop_q) begin
          erase_req  <= 1'b1;
          erase_busy <= 1'b1;
          pend_q     <= rop_set_value;
        end else begin
          rop_q <= rop_set_value;
        end
      end
    end
  end
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import fg_pkg::*;
#(
  parameter int PROG_BYTES = 8192,
  parameter int DATA_BYTES = 640,
  parameter int PAGE_BYTES = 64,
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [PAGE_W-1:0] cfg_pages,
  input  logic              req_valid,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic              rop,
  input  logic              busy,
  input  logic              prog_open,
  input  logic              data_open,
  input  logic              err_clr,
  output logic              loaded,
  output logic              grant,
  output logic              deny,
  output logic              err_flag
);
  localparam int PROG_PAGES = PROG_BYTES / PAGE_BYTES;
  localparam int LIM_W      = $clog2(PROG_BYTES + 1);

  logic [PAGE_W-1:0] pages_q;
  logic [PAGE_W-1:0] eff_pages;
  logic [LIM_W-1:0]  boot_lim;
  logic [LIM_W-1:0]  addr_x;
  logic              in_range;
  logic              ok;

  always_comb begin
    eff_pages = (pages_q > PAGE_W'(PROG_PAGES)) ? PAGE_W'(PROG_PAGES) : pages_q;
    boot_lim  = LIM_W'(eff_pages) * LIM_W'(PAGE_BYTES);
    addr_x    = LIM_W'(req_addr);
    in_range  = req_space ? (addr_x < LIM_W'(DATA_BYTES)) : (addr_x < LIM_W'(PROG_BYTES));
    ok        = 1'b0;
    if (loaded && !busy && in_range) begin
      case (acc_mode_e'(req_mode))
        MODE_IAP: begin
          if (!req_write)     ok = 1'b1;
          else if (req_space) ok = data_open;
          else                ok = prog_open && (addr_x >= boot_lim);
        end
        MODE_ICP, MODE_DBG: ok = !rop;
        default:            ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded   <= 1'b0;
      pages_q  <= '0;
      grant    <= 1'b0;
      deny     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (!loaded && cfg_load) begin
        loaded  <= 1'b1;
        pages_q <= cfg_pages;
      end
      grant <= req_valid && ok;
      deny  <= req_valid && !ok;
      if (req_valid && req_write && !ok) err_flag <= 1'b1;
      else if (err_clr)                  err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int PROG_BYTES = 8192,
  parameter int DATA_BYTES = 640,
  parameter int PAGE_BYTES = 64,
  parameter logic [7:0] PKEY_A = 8'h3C,
  parameter logic [7:0] PKEY_B = 8'hA5,
  parameter logic [7:0] DKEY_A = 8'hA5,
  parameter logic [7:0] DKEY_B = 8'h3C,
  localparam int ADDR_W = $clog2(PROG_BYTES),
  localparam int PAGE_W = $clog2(PROG_BYTES / PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [PAGE_W-1:0] cfg_pages,
  input  logic              cfg_rop,
  input  logic              req_valid,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic              key_valid,
  input  logic              key_space,
  input  logic [7:0]        key_data,
  input  logic              lock_cmd,
  input  logic              rop_set_valid,
  input  logic              rop_set_value,
  input  logic              err_clr,
  input  logic              erase_done,
  output logic              grant,
  output logic              deny,
  output logic              err_flag,
  output logic              erase_req,
  output logic              erase_busy
);
  logic       loaded;
  logic       rop_q;
  logic [1:0] open_v;

  for (genvar s = 0; s < 2; s++) begin : g_space
    localparam logic [7:0] KA = (s == 0) ? PKEY_A : DKEY_A;
    localparam logic [7:0] KB = (s == 0) ? PKEY_B : DKEY_B;
    fg_keyseq #(.KEY_A(KA), .KEY_B(KB), .SPACE(1'(s))) u_key (
      .clk      (clk),
      .rst      (rst),
      .key_valid(key_valid),
      .key_space(key_space),
      .key_data (key_data),
      .lock_cmd (lock_cmd),
      .unlocked (open_v[s])
    );
  end

  fg_rop_ctl u_rop (
    .clk          (clk),
    .rst          (rst),
    .loaded       (loaded),
    .cfg_load     (cfg_load),
    .cfg_rop      (cfg_rop),
    .rop_set_valid(rop_set_valid),
    .rop_set_value(rop_set_value),
    .erase_done   (erase_done),
    .rop_q        (rop_q),
    .erase_req    (erase_req),
    .erase_busy   (erase_busy)
  );

  fg_decide #(
    .PROG_BYTES(PROG_BYTES),
    .DATA_BYTES(DATA_BYTES),
    .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_pages(cfg_pages),
    .req_valid(req_valid),
    .req_space(req_space),
    .req_addr (req_addr),
    .req_write(req_write),
    .req_mode (req_mode),
    .rop      (rop_q),
    .busy     (erase_busy),
    .prog_open(open_v[0]),
    .data_open(open_v[1]),
    .err_clr  (err_clr),
    .loaded   (loaded),
    .grant    (grant),
    .deny     (deny),
    .err_flag (err_flag)
  );
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       grant,
  input logic       deny,
  input logic       err_flag,
  input logic       erase_req,
  input logic       erase_busy,
  input logic       rop_q
);
  p_one_answer_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((grant || deny) == $past(req_valid)));

  p_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny));

  p_rop_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (rop_q && req_valid && req_mode != 2'd0) |=> !grant);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_busy) |-> erase_req);

  p_busy_deny_r10: assert property (@(posedge clk) disable iff (rst)
    erase_busy |=> !grant);

  p_err_rise_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> deny);
endmodule

bind flash_guard fg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .grant     (grant),
  .deny      (deny),
  .err_flag  (err_flag),
  .erase_req (erase_req),
  .erase_busy(erase_busy),
  .rop_q     (rop_q)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_load = 0, cfg_rop = 0;
  logic [7:0]  cfg_pages = 0;
  logic        req_valid = 0, req_space = 0, req_write = 0;
  logic [12:0] req_addr = 0;
  logic [1:0]  req_mode = 0;
  logic        key_valid = 0, key_space = 0, lock_cmd = 0;
  logic [7:0]  key_data = 0;
  logic        rop_set_valid = 0, rop_set_value = 0, err_clr = 0, erase_done = 0;
  logic        grant, deny, err_flag, erase_req, erase_busy;

  flash_guard u_flash_guard (.*);

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  bit m_loaded, m_rop, m_busy, m_pend, m_err, m_grant, m_deny, m_ereq;
  int m_pages, m_pk, m_dk; // key state: 0 locked, 1 half, 2 open, 3 jammed

  function automatic int key_step(int st, int b, int ka, int kb);
    if (st == 0) return (b == ka) ? 1 : 3;
    if (st == 1) return (b == kb) ? 2 : 3;
    return st;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_loaded = 0; m_rop = 0; m_busy = 0; m_pend = 0; m_err = 0;
      m_grant = 0; m_deny = 0; m_ereq = 0; m_pages = 0; m_pk = 0; m_dk = 0;
    end else begin
      bit ok;
      int lim, a;
      a   = int'(req_addr);
      lim = ((m_pages > 128) ? 128 : m_pages) * 64;
      ok  = 0;
      if (m_loaded && !m_busy && !(req_space && a >= 640)) begin
        if (req_mode == 0) begin
          if (!req_write) ok = 1;
          else if (req_space) ok = (m_dk == 2);
          else ok = (m_pk == 2) && (a >= lim);
        end else if (req_mode == 1 || req_mode == 2) ok = !m_rop;
      end
      m_grant = req_valid && ok;
      m_deny  = req_valid && !ok;
      if (req_valid && req_write && !ok) m_err = 1;
      else if (err_clr) m_err = 0;
      if (lock_cmd) begin
        if (m_pk != 3) m_pk = 0;
        if (m_dk != 3) m_dk = 0;
      end else if (key_valid) begin
        if (key_space) m_dk = key_step(m_dk, key_data, 'hA5, 'h3C);
        else           m_pk = key_step(m_pk, key_data, 'h3C, 'hA5);
      end
      m_ereq = 0;
      if (!m_loaded && cfg_load) m_rop = cfg_rop;
      else if (m_busy) begin
        if (erase_done) begin m_busy = 0; m_rop = m_pend; end
      end else if (m_loaded && rop_set_valid && rop_set_value != m_rop) begin
        if (m_rop) begin m_ereq = 1; m_busy = 1; m_pend = rop_set_value; end
        else m_rop = rop_set_value;
      end
      if (!m_loaded && cfg_load) begin m_loaded = 1; m_pages = int'(cfg_pages); end
    end
  end

  task automatic cmp(string nm, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %0b at %0t", cur_req, nm, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      cmp("grant", grant, m_grant);
      cmp("deny", deny, m_deny);
      cmp("err_flag", err_flag, m_err);
      cmp("erase_req", erase_req, m_ereq);
      cmp("erase_busy", erase_busy, m_busy);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(bit sp, int addr, bit wr, int mode);
    req_valid = 1; req_space = sp; req_addr = 13'(addr); req_write = wr; req_mode = 2'(mode);
    cyc();
    req_valid = 0; req_write = 0;
  endtask

  task automatic key(bit sp, int b);
    key_valid = 1; key_space = sp; key_data = 8'(b);
    cyc();
    key_valid = 0;
  endtask

  task automatic load(int pages, bit rp);
    cfg_load = 1; cfg_pages = 8'(pages); cfg_rop = rp;
    cyc();
    cfg_load = 0;
  endtask

  task automatic do_reset();
    rst = 1; cyc(2); rst = 0;
  endtask

  task automatic set_rop(bit v);
    rop_set_valid = 1; rop_set_value = v;
    cyc();
    rop_set_valid = 0;
  endtask

  task automatic finish_run();
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    // R2: denied before settings are loaded; R11 denied write raises flag
    cur_req = "R2";
    access(0, 0, 0, 0);
    cur_req = "R11";
    access(0, 300, 1, 0);
    cyc();
    err_clr = 1; cyc(); err_clr = 0;
    cur_req = "R2";
    cfg_load = 1; cfg_pages = 4; req_valid = 1; req_addr = 1000; req_mode = 0;
    cyc();
    cfg_load = 0; req_valid = 0;
    load(0, 1);
    access(0, 100, 0, 0);
    // R7: reads whatever the locks
    cur_req = "R7";
    access(0, 0, 0, 0);
    access(1, 639, 0, 0);
    cur_req = "R5";
    access(1, 640, 0, 0);
    // R4 / R3: program unlock and boot boundary
    cur_req = "R4";
    access(0, 300, 1, 0);
    key(0, 'h3C); key(0, 'hA5);
    access(0, 256, 1, 0);
    cur_req = "R3";
    access(0, 255, 1, 0);
    access(0, 0, 1, 0);
    // R6: lock command, key in same cycle loses
    cur_req = "R6";
    lock_cmd = 1; key_valid = 1; key_space = 0; key_data = 'h3C; cyc();
    lock_cmd = 0; key_valid = 0;
    access(0, 256, 1, 0);
    // R5: data unlock
    cur_req = "R5";
    access(1, 10, 1, 0);
    key(1, 'hA5); key(1, 'h3C);
    access(1, 10, 1, 0);
    access(1, 700, 1, 0);
    // R6: wrong key jams program space
    cur_req = "R6";
    key(0, 'h00);
    key(0, 'h3C); key(0, 'hA5);
    access(0, 4000, 1, 0);
    lock_cmd = 1; cyc(); lock_cmd = 0;
    key(0, 'h3C); key(0, 'hA5);
    access(0, 4000, 1, 0);
    // R8: modes with protection off
    cur_req = "R8";
    access(0, 0, 1, 1);
    access(1, 5, 0, 2);
    access(0, 9, 0, 3);
    // R9: protection on without erase
    cur_req = "R9";
    set_rop(1);
    cur_req = "R8";
    access(0, 0, 0, 1);
    access(1, 3, 1, 2);
    access(0, 0, 0, 0);
    // R9: turning off forces erase
    cur_req = "R9";
    set_rop(0);
    cur_req = "R10";
    access(0, 0, 0, 0);
    set_rop(1);
    cur_req = "R11";
    err_clr = 1; req_valid = 1; req_space = 0; req_addr = 0; req_write = 1; req_mode = 1;
    cyc();
    err_clr = 0; req_valid = 0; req_write = 0;
    cyc(3);
    // erase done coincides with request
    cur_req = "R10";
    erase_done = 1; req_valid = 1; req_addr = 50; req_mode = 1;
    cyc();
    erase_done = 0; req_valid = 0;
    cur_req = "R9";
    access(0, 50, 0, 1);
    cur_req = "R10";
    erase_done = 1; cyc(); erase_done = 0;
    access(0, 60, 0, 1);
    cur_req = "R11";
    err_clr = 1; cyc(); err_clr = 0;
    access(0, 7, 0, 3);
    // R3: oversized boundary covers all; zero covers none
    cur_req = "R3";
    do_reset();
    load(200, 0);
    key(0, 'h3C); key(0, 'hA5);
    access(0, 8191, 1, 0);
    do_reset();
    load(0, 0);
    key(0, 'h3C); key(0, 'hA5);
    access(0, 0, 1, 0);
    cur_req = "R1";
    cyc(3);
    finish_run();
  end
endmodule